// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor core in which every instruction finishes in one clock period. It fetches a word from a local instruction store addressed by the program counter, decodes it, reads two operands from a 32-entry register file, computes in the ALU and, in the same period, writes the result to the register file or the local data store, and selects the next program counter. Nine instructions are recognised: word load and store, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-on-equal and an absolute jump.

Decoding has two stages. A main decoder maps the 6-bit opcode to datapath steering and a 2-bit operation class. A second stage combines that class with the function field of register-format words to pick a 3-bit ALU operation. Both memory arrays are word-addressed and are filled through a loading port while the core is held in reset. Trace outputs show the program counter and every register-file or data-store write as it is issued, so the core's progress can be followed at its ports.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset forces the program counter to 0 on the next rising edge, and while reset is high no register-file or data-store write is issued (both write strobes read 0).
- R2: An instruction that is neither a taken branch nor a jump advances the program counter by 4 on the next edge.
- R3: The main decoder recognises opcode 0 (register format), 35 (load), 43 (store), 4 (branch-on-equal) and 2 (jump); register format writes the register named by bits 15:11, a load writes the register named by bits 20:16, and store, branch and jump write no register.
- R4: ALU operation codes are 000 and, 001 or, 010 add, 110 subtract, 111 set-less-than; operation class 00 (load/store) selects add, 01 (branch) selects subtract, 10 defers to the function field.
- R5: In register format, function 100000 writes rs+rt and function 100010 writes rs−rt, both modulo 2^32.
- R6: In register format, function 100100 writes the bitwise AND of rs and rt, and function 100101 writes their bitwise OR.
- R7: In register format, function 101010 writes 1 when rs is below rt as signed 32-bit numbers and 0 otherwise; bits 31:1 of the result are always 0.
- R8: A load writes the data-store word at byte address rs + sign-extended bits 15:0 into rt; the word index is the byte address shifted right by 2.
- R9: A store writes rt to the data-store word at byte address rs + sign-extended bits 15:0.
- R10: Branch-on-equal with rs equal to rt loads PC+4 plus the sign-extended offset shifted left by 2 (backward offsets included); with unequal operands the PC advances by 4.
- R11: A jump loads the program counter with PC bits 31:28, then bits 25:0 of the instruction, then two zero bits.
- R12: Register 0 reads as zero at all times; a write addressed to it leaves it zero.
- R13: With the loading strobe high, the word on the loading data bus is written at the given word index of the instruction store (select 0) or the data store (select 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_we_i | input | 1 | Loading-port write strobe |
| ld_sel_i | input | 1 | Loading target: 0 instruction store, 1 data store |
| ld_addr_i | input | LD_AW | Loading word index |
| ld_data_i | input | 32 | Loading data word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register-file write issued this cycle |
| rf_waddr_o | output | 5 | Register index being written |
| rf_wdata_o | output | 32 | Value being written to the register file |
| dm_we_o | output | 1 | Data-store write issued this cycle |
| dm_addr_o | output | 32 | Byte address of the data-store access |
| dm_wdata_o | output | 32 | Value being stored |

## Verification
The bench runs a program whose expected register writes, stores and program-counter trail are queued in advance and compared as the core issues them. It targets signed versus unsigned comparison in set-less-than (a core comparing unsigned would write 0 for −3 < 5), a write aimed at register 0 followed by a store of register 0 (a core that keeps the value would store 10 instead of 0), and a not-taken branch next to a taken forward and a taken backward branch (a wrong offset scale or sign would leave the PC trail and let guard stores slip into the write stream). A load of a value stored earlier in the same run catches wrong word indexing, and a reset asserted mid-run must bring the PC back to 0 with both write strobes low.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam int XLEN = 32;

   typedef enum logic [5:0] {
      OPC_RFMT  = 6'd0,
      OPC_JUMP  = 6'd2,
      OPC_BEQ   = 6'd4,
      OPC_LOAD  = 6'd35,
      OPC_STORE = 6'd43
   } opcode_e;

   typedef enum logic [1:0] {
      CLS_MEM = 2'b00,
      CLS_BR  = 2'b01,
      CLS_FN  = 2'b10
   } op_class_e;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [5:0] {
      FN_ADD = 6'b100000,
      FN_SUB = 6'b100010,
      FN_AND = 6'b100100,
      FN_OR  = 6'b100101,
      FN_SLT = 6'b101010
   } funct_e;

   typedef struct packed {
      logic      dst_rd;
      logic      b_imm;
      logic      wb_mem;
      logic      rf_wr;
      logic      dm_rd;
      logic      dm_wr;
      logic      br;
      logic      jmp;
      op_class_e cls;
   } ctl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
   import sc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [5:0] opcode_i,
   output ctl_t       ctl_o
);

   always_comb begin
      ctl_o = '{dst_rd: 1'b0, b_imm: 1'b0, wb_mem: 1'b0, rf_wr: 1'b0,
                dm_rd: 1'b0, dm_wr: 1'b0, br: 1'b0, jmp: 1'b0, cls: CLS_MEM};
      case (opcode_i)
         OPC_RFMT: begin
            ctl_o.dst_rd = 1'b1;
            ctl_o.rf_wr  = 1'b1;
            ctl_o.cls    = CLS_FN;
         end
         OPC_LOAD: begin
            ctl_o.b_imm  = 1'b1;
            ctl_o.wb_mem = 1'b1;
            ctl_o.rf_wr  = 1'b1;
            ctl_o.dm_rd  = 1'b1;
         end
         OPC_STORE: begin
            ctl_o.b_imm  = 1'b1;
            ctl_o.dm_wr  = 1'b1;
         end
         OPC_BEQ: begin
            ctl_o.br     = 1'b1;
            ctl_o.cls    = CLS_BR;
         end
         OPC_JUMP: begin
            ctl_o.jmp    = 1'b1;
         end
         default: ;
      endcase
   end

   AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl_o.rf_wr, ctl_o.dm_wr, ctl_o.br, ctl_o.jmp})) else $error("decoder effects overlap"); // R3

endmodule

// File: rtl/sc_alu_ctl.sv
module sc_alu_ctl
   import sc_pkg::*;
(
   input  op_class_e  cls_i,
   input  logic [5:0] funct_i,
   output alu_op_e    op_o
);

   always_comb begin
      op_o = ALU_ADD;
      unique case (cls_i)
         CLS_MEM: op_o = ALU_ADD;
         CLS_BR:  op_o = ALU_SUB;
         CLS_FN: begin
            case (funct_i)
               FN_ADD:  op_o = ALU_ADD;
               FN_SUB:  op_o = ALU_SUB;
               FN_AND:  op_o = ALU_AND;
               FN_OR:   op_o = ALU_OR;
               FN_SLT:  op_o = ALU_SLT;
               default: op_o = ALU_ADD;
            endcase
         end
         default: op_o = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int W           = 32,
   parameter bit SLT_VIA_SUB = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  alu_op_e      op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o,
   output logic         zero_o
);

   logic [W-1:0] diff;
   logic         lt;

   assign diff = a_i - b_i;

   generate
      if (SLT_VIA_SUB) begin : g_slt_sub
         logic ovf;
         assign ovf = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ diff[W-1]);
         assign lt  = diff[W-1] ^ ovf;
      end else begin : g_slt_cmp
         assign lt  = $signed(a_i) < $signed(b_i);
      end
   endgenerate

   always_comb begin
      case (op_i)
         ALU_AND: y_o = a_i & b_i;
         ALU_OR:  y_o = a_i | b_i;
         ALU_ADD: y_o = a_i + b_i;
         ALU_SUB: y_o = diff;
         ALU_SLT: y_o = {{(W-1){1'b0}}, lt};
         default: y_o = a_i + b_i;
      endcase
   end

   assign zero_o = (y_o == '0);

   AST_SLT_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (op_i == ALU_SLT) |-> (y_o[W-1:1] == '0)) else $error("slt upper bits set"); // R7
   AST_ZERO_ON_EQUAL: assert property (@(posedge clk) disable iff (rst)
      (op_i == ALU_SUB && a_i == b_i) |-> zero_o) else $error("zero flag missing"); // R10

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W     = 32,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ra1_i,
   input  logic [AW-1:0] ra2_i,
   output logic [W-1:0]  rd1_o,
   output logic [W-1:0]  rd2_o,
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [W-1:0]  wd_i
);

   logic [W-1:0] regs [NREGS];

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         if (i == 0) begin : g_zero
            assign regs[i] = '0;
         end else begin : g_flop
            always_ff @(posedge clk) begin
               if (rst)
                  regs[i] <= '0;
               else if (we_i && wa_i == AW'(i))
                  regs[i] <= wd_i;
            end
         end
      end
   endgenerate

   assign rd1_o = regs[ra1_i];
   assign rd2_o = regs[ra2_i];

   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
      (we_i && wa_i != '0 && !(|$past(rst))) |=> (ra1_i != $past(wa_i) || rd1_o == $past(wd_i))) else $error("write lost"); // R12
   AST_R0_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (we_i && wa_i == '0) |=> (ra2_i != '0 || rd2_o == '0)) else $error("register 0 altered"); // R12

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int IMEM_WORDS  = 64,
   parameter int DMEM_WORDS  = 64,
   parameter int NREGS       = 32,
   parameter int LD_AW       = 8,
   parameter bit SLT_VIA_SUB = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_we_i,
   input  logic             ld_sel_i,
   input  logic [LD_AW-1:0] ld_addr_i,
   input  logic [31:0]      ld_data_i,
   output logic [31:0]      pc_o,
   output logic             rf_we_o,
   output logic [4:0]       rf_waddr_o,
   output logic [31:0]      rf_wdata_o,
   output logic             dm_we_o,
   output logic [31:0]      dm_addr_o,
   output logic [31:0]      dm_wdata_o
);

   localparam int IAW = $clog2(IMEM_WORDS);
   localparam int DAW = $clog2(DMEM_WORDS);
   localparam int RAW = $clog2(NREGS);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("core expects a 32-bit word");
      end
      if (NREGS != 32) begin : g_bad_nregs
         $error("register index fields are 5 bits, NREGS must be 32");
      end
      if (LD_AW < IAW || LD_AW < DAW) begin : g_bad_ldaw
         $error("loading index narrower than a store index");
      end
      if ((1 << IAW) != IMEM_WORDS || (1 << DAW) != DMEM_WORDS) begin : g_bad_depth
         $error("store depths must be powers of two");
      end
   endgenerate

   logic [31:0] imem [IMEM_WORDS];
   logic [31:0] dmem [DMEM_WORDS];

   logic [31:0] pc_q, pc_d, pc_plus4, br_target, jmp_target;
   logic [31:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y, wb_val, ld_word;
   logic [4:0]  wr_reg;
   logic        zero, take_br, rf_we, dm_we;
   ctl_t        ctl;
   alu_op_e     alu_op;

   // fetch
   assign instr = imem[pc_q[IAW+1:2]];

   always_ff @(posedge clk) begin
      if (ld_we_i && !ld_sel_i)
         imem[ld_addr_i[IAW-1:0]] <= ld_data_i;
   end

   // decode
   sc_main_dec u_dec (
      .clk      (clk),
      .rst      (rst),
      .opcode_i (instr[31:26]),
      .ctl_o    (ctl)
   );

   sc_alu_ctl u_alu_ctl (
      .cls_i   (ctl.cls),
      .funct_i (instr[5:0]),
      .op_o    (alu_op)
   );

   assign imm_sx = {{16{instr[15]}}, instr[15:0]};
   assign wr_reg = ctl.dst_rd ? instr[15:11] : instr[20:16];
   assign rf_we  = ctl.rf_wr & ~rst;

   sc_regfile #(
      .W     (32),
      .NREGS (NREGS)
   ) u_rf (
      .clk   (clk),
      .rst   (rst),
      .ra1_i (instr[25:21]),
      .ra2_i (instr[20:16]),
      .rd1_o (rs_val),
      .rd2_o (rt_val),
      .we_i  (rf_we),
      .wa_i  (wr_reg),
      .wd_i  (wb_val)
   );

   // execute
   assign alu_b = ctl.b_imm ? imm_sx : rt_val;

   sc_alu #(
      .W           (32),
      .SLT_VIA_SUB (SLT_VIA_SUB)
   ) u_alu (
      .clk    (clk),
      .rst    (rst),
      .op_i   (alu_op),
      .a_i    (rs_val),
      .b_i    (alu_b),
      .y_o    (alu_y),
      .zero_o (zero)
   );

   // data store
   assign dm_we   = ctl.dm_wr & ~rst;
   assign ld_word = dmem[alu_y[DAW+1:2]];

   always_ff @(posedge clk) begin
      if (ld_we_i && ld_sel_i)
         dmem[ld_addr_i[DAW-1:0]] <= ld_data_i;
      else if (dm_we)
         dmem[alu_y[DAW+1:2]] <= rt_val;
   end

   assign wb_val = ctl.wb_mem ? ld_word : alu_y;

   // next program counter
   assign pc_plus4   = pc_q + 32'd4;
   assign br_target  = pc_plus4 + {imm_sx[29:0], 2'b00};
   assign jmp_target = {pc_q[31:28], instr[25:0], 2'b00};
   assign take_br    = ctl.br & zero;

   always_comb begin
      if (ctl.jmp)
         pc_d = jmp_target;
      else if (take_br)
         pc_d = br_target;
      else
         pc_d = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_d;
   end

   // trace
   assign pc_o       = pc_q;
   assign rf_we_o    = rf_we;
   assign rf_waddr_o = wr_reg;
   assign rf_wdata_o = wb_val;
   assign dm_we_o    = dm_we;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = rt_val;

   logic past_ok;
   always_ff @(posedge clk) past_ok <= 1'b1;

   AST_PC_RESET: assert property (@(posedge clk)
      (past_ok && $past(rst)) |-> (pc_o == 32'd0)) else $error("pc not cleared"); // R1
   AST_QUIET_IN_RESET: assert property (@(posedge clk)
      rst |-> (!rf_we_o && !dm_we_o)) else $error("write during reset"); // R1
   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (!ctl.jmp && !take_br) |=> (pc_o == $past(pc_o) + 32'd4)) else $error("pc step wrong"); // R2
   AST_MEM_CLASS_ADDS: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OPC_LOAD || instr[31:26] == OPC_STORE) |-> (alu_op == ALU_ADD)) else $error("address op wrong"); // R4
   AST_BEQ_SUBTRACTS: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OPC_BEQ) |-> (alu_op == ALU_SUB && !rf_we_o && !dm_we_o)) else $error("branch op wrong"); // R4
   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OPC_JUMP) |=> (pc_o[27:0] == {$past(instr[25:0]), 2'b00})) else $error("jump target wrong"); // R11

endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

   localparam int LD_AW = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             ld_we = 1'b0;
   logic             ld_sel = 1'b0;
   logic [LD_AW-1:0] ld_addr = '0;
   logic [31:0]      ld_data = '0;
   logic [31:0]      pc;
   logic             rf_we, dm_we;
   logic [4:0]       rf_waddr;
   logic [31:0]      rf_wdata, dm_addr, dm_wdata;

   always #2.5 clk = ~clk;

   sc_core #(.LD_AW(LD_AW)) u_dut (
      .clk        (clk),
      .rst        (rst),
      .ld_we_i    (ld_we),
      .ld_sel_i   (ld_sel),
      .ld_addr_i  (ld_addr),
      .ld_data_i  (ld_data),
      .pc_o       (pc),
      .rf_we_o    (rf_we),
      .rf_waddr_o (rf_waddr),
      .rf_wdata_o (rf_wdata),
      .dm_we_o    (dm_we),
      .dm_addr_o  (dm_addr),
      .dm_wdata_o (dm_wdata)
   );

   typedef struct {
      bit          is_mem;
      logic [31:0] addr;
      logic [31:0] data;
      string       tag;
   } evt_t;

   evt_t        exp_q[$];
   logic [31:0] pc_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          mon_on = 1'b0;
   bit          done = 1'b0;

   function automatic logic [31:0] rfmt(int rs, int rt, int rd, logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] ifmt(logic [5:0] op, int rs, int rt, int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   function automatic logic [31:0] jfmt(int widx);
      return {6'd2, 26'(widx)};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
      end
   endtask

   task automatic load_word(bit sel, int idx, logic [31:0] w);
      ld_we   = 1'b1;
      ld_sel  = sel;
      ld_addr = LD_AW'(idx);
      ld_data = w;
      @(posedge clk); #1;
      ld_we   = 1'b0;
   endtask

   task automatic push_rf(int r, logic [31:0] v, string tag);
      exp_q.push_back('{is_mem: 1'b0, addr: 32'(r), data: v, tag: tag});
   endtask

   task automatic push_mem(int a, logic [31:0] v, string tag);
      exp_q.push_back('{is_mem: 1'b1, addr: 32'(a), data: v, tag: tag});
   endtask

   // monitor: compares the PC trail and every issued write
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (pc_q.size() > 0) begin
               logic [31:0] ep;
               ep = pc_q.pop_front();
               check("R2/R10/R11 pc", pc, ep);
            end
            if (rf_we || dm_we) begin
               if (exp_q.size() == 0) begin
                  n_chk++; n_bad++;
                  $display("FAIL R9/R10 unexpected write actual=%08h expected=none", dm_we ? dm_addr : 32'(rf_waddr));
               end else begin
                  evt_t e;
                  e = exp_q.pop_front();
                  check({e.tag, " kind"}, {31'd0, dm_we}, {31'd0, e.is_mem});
                  check({e.tag, " addr"}, dm_we ? dm_addr : 32'(rf_waddr), e.addr);
                  check({e.tag, " data"}, dm_we ? dm_wdata : rf_wdata, e.data);
               end
            end
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] prog [26];
      @(posedge clk); #1;
      // data store preload (R13)
      load_word(1'b1, 0, 32'd5);
      load_word(1'b1, 1, 32'hFFFF_FFFD);
      load_word(1'b1, 2, 32'h0F0F_00FF);
      load_word(1'b1, 3, 32'h00FF_0F0F);

      prog[0]  = ifmt(6'd35, 0, 1, 0);          // lw r1
      prog[1]  = ifmt(6'd35, 0, 2, 4);          // lw r2
      prog[2]  = ifmt(6'd35, 0, 3, 8);          // lw r3
      prog[3]  = ifmt(6'd35, 0, 4, 12);         // lw r4
      prog[4]  = rfmt(1, 2, 5, 6'b100000);      // add
      prog[5]  = rfmt(1, 2, 6, 6'b100010);      // sub
      prog[6]  = rfmt(3, 4, 7, 6'b100100);      // and
      prog[7]  = rfmt(3, 4, 8, 6'b100101);      // or
      prog[8]  = rfmt(2, 1, 9, 6'b101010);      // slt -3<5
      prog[9]  = rfmt(1, 2, 10, 6'b101010);     // slt 5<-3
      prog[10] = rfmt(1, 1, 0, 6'b100000);      // add into r0
      prog[11] = ifmt(6'd43, 0, 0, 16);         // sw r0
      prog[12] = ifmt(6'd43, 0, 8, 24);         // sw r8
      prog[13] = ifmt(6'd4, 1, 2, 5);           // beq not taken
      prog[14] = ifmt(6'd4, 9, 9, 2);           // beq taken forward
      prog[15] = ifmt(6'd43, 0, 1, 28);         // guard
      prog[16] = ifmt(6'd43, 0, 1, 28);         // guard
      prog[17] = jfmt(20);                      // j 80
      prog[18] = ifmt(6'd43, 0, 2, 32);         // sw r2
      prog[19] = jfmt(23);                      // j 92
      prog[20] = ifmt(6'd4, 0, 0, -3);          // beq backward
      prog[21] = ifmt(6'd43, 0, 1, 28);         // guard
      prog[22] = ifmt(6'd43, 0, 1, 28);         // guard
      prog[23] = ifmt(6'd35, 0, 11, 24);        // lw stored word
      prog[24] = ifmt(6'd43, 0, 11, 36);        // sw r11
      prog[25] = ifmt(6'd4, 0, 0, -1);          // self loop
      for (int i = 0; i < 26; i++) load_word(1'b0, i, prog[i]);

      // reset state (R1): pc 0 and no writes while held
      @(negedge clk);
      check("R1 pc in reset", pc, 32'd0);
      check("R1 strobes in reset", {30'd0, rf_we, dm_we}, 32'd0);

      push_rf(1, 32'd5, "R8 lw r1");
      push_rf(2, 32'hFFFF_FFFD, "R8 lw r2");
      push_rf(3, 32'h0F0F_00FF, "R8 lw r3");
      push_rf(4, 32'h00FF_0F0F, "R8 lw r4");
      push_rf(5, 32'd2, "R5 add");
      push_rf(6, 32'd8, "R5 sub");
      push_rf(7, 32'h000F_000F, "R6 and");
      push_rf(8, 32'h0FFF_0FFF, "R6 or");
      push_rf(9, 32'd1, "R7 slt signed true");
      push_rf(10, 32'd0, "R7 slt signed false");
      push_rf(0, 32'd10, "R12 write to r0");
      push_mem(16, 32'd0, "R12 r0 still zero");
      push_mem(24, 32'h0FFF_0FFF, "R9 sw r8");
      push_mem(32, 32'hFFFF_FFFD, "R10 backward branch path");
      push_rf(11, 32'h0FFF_0FFF, "R8 lw after sw");
      push_mem(36, 32'h0FFF_0FFF, "R9 sw r11");

      for (int a = 0; a <= 56; a += 4) pc_q.push_back(32'(a));
      pc_q.push_back(32'd68);   // R10 taken forward
      pc_q.push_back(32'd80);   // R11 jump
      pc_q.push_back(32'd72);   // R10 taken backward
      pc_q.push_back(32'd76);
      pc_q.push_back(32'd92);   // R11 jump
      pc_q.push_back(32'd96);
      pc_q.push_back(32'd100);
      pc_q.push_back(32'd100);
      pc_q.push_back(32'd100);

      @(posedge clk); #1;
      rst    = 1'b0;
      mon_on = 1'b1;
      for (int i = 0; i < 40; i++) @(posedge clk);
      #1;
      check("R3/R9 all expected writes seen", 32'(exp_q.size()), 32'd0);
      check("R2 pc trail consumed", 32'(pc_q.size()), 32'd0);

      // mid-run reset (R1)
      mon_on = 1'b0;
      rst = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      check("R1 pc after mid-run reset", pc, 32'd0);
      check("R1 no write strobe in reset", {30'd0, rf_we, dm_we}, 32'd0);
      rst = 1'b0;
      @(posedge clk); #1;
      @(negedge clk);
      check("R2 pc after reset release", pc, 32'd4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule